// File: doc/BRIEF.md
# Counter-Ramp and Tracking ADC Controller

This block is the digital half of a counter-type analog-to-digital converter. It drives an N-bit code into an external DAC and reads back a single comparator bit, `cmpAbove`, that is high when the DAC output is above the held analog input. The resulting code is reported on `resultCode` together with `resultValid`. The analog parts (sample-and-hold, DAC, comparator) sit outside the block.

In ramp mode (`trackMode` low), a `startReq` pulse clears the counter to zero. The counter then rises by one per clock for as long as the comparator says the DAC is still at or below the input. It freezes on the first clock where the comparator trips. The input must be held steady by an external sample-and-hold for the whole ramp, and the conversion time grows with the input level. If the count reaches all ones without a trip, it stops there and raises `fullScale`.

In tracking mode (`trackMode` high), the counter runs on every clock. It steps down when the DAC is above the input and up otherwise, and it saturates at both ends. The code therefore follows a slowly moving input without restarting from zero. A result is published whenever the step direction reverses, which marks the point where the code brackets the input.

Top module: `ramp_track_adc`

## Requirements
- R1: After reset `dacCode` is 0, and `resultValid` and `fullScale` are 0.
- R2: In ramp mode, a clock edge that samples `startReq` high sets `dacCode` to 0 and `resultValid` and `fullScale` to 0. This holds whether a ramp is idle, running or finished.
- R3: During a ramp, each clock edge at which `cmpAbove` is 0 (DAC output not above the input) and the code is below all ones raises `dacCode` by exactly one.
- R4: The first ramp edge that samples `cmpAbove` high stops the count and latches the current code into `resultCode`, with `resultValid` high after that same edge. The number of edges from the start edge to `resultValid` equals the result code plus one.
- R5: Once a ramp result is valid, `dacCode`, `resultCode` and `resultValid` stay unchanged until the next start in ramp mode or a change of mode.
- R6: If a ramp reaches all ones with `cmpAbove` still 0, the next edge stops it without wrapping. `resultCode` is then all ones and `fullScale` is 1. If the comparator trips exactly at all ones, `fullScale` stays 0.
- R7: In tracking mode, every clock steps `dacCode` down by one when `cmpAbove` is 1 and up by one otherwise. A slowly moving input is followed to within one LSB.
- R8: In tracking mode the code saturates: it holds at 0 when asked to step down and at all ones when asked to step up.
- R9: In tracking mode, `resultValid` is high after an edge whose step direction differs from the direction of the previous tracking edge. At that edge `resultCode` captures the code held just before the step. While the code moves steadily in one direction, `resultValid` is 0.
- R10: `startReq` has no effect while `trackMode` is high.
- R11: When `trackMode` falls, the next edge leaves `dacCode` unchanged and drops `resultValid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Starts a ramp conversion (ramp mode only) |
| trackMode | input | 1 | 1 = tracking mode, 0 = ramp mode |
| cmpAbove | input | 1 | Comparator: 1 when DAC output is above the held input |
| dacCode | output | W | Code driven to the external DAC |
| resultCode | output | W | Latched conversion result |
| resultValid | output | 1 | Result is valid (ramp: until restart; tracking: after a reversal) |
| fullScale | output | 1 | Ramp ended at all ones without a comparator trip |

## Verification
The bench builds the block with W = 6, so full scale is 63 and a complete ramp lasts at most 64 edges. At this width every reachable input level, from below zero to above full scale, can be swept through a ramp conversion. The exact latency of each conversion is checked against the code it produces. Tracking is checked against an input that moves slowly up and down across most of the range. It is also checked held at constant levels, driven past both rails, and across a mode exit.

// File: rtl/rta_pkg.sv
package rta_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clear;    // force counter to zero
    logic inc;      // step up (datapath saturates)
    logic dec;      // step down (datapath saturates)
    logic capture;  // copy counter into result register
  } rtaStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RAMP  = 2'd1,
    ST_DONE  = 2'd2,
    ST_TRACK = 2'd3
  } rtaState_t;
endpackage

// File: rtl/rta_datapath.sv
module rta_datapath
  import rta_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  rtaStrobe_t   strb,
  output logic [W-1:0] count,
  output logic [W-1:0] result,
  output logic         atMax
);
  localparam logic [W-1:0] MAX_CODE  = {W{1'b1}};
  localparam logic [W-1:0] ZERO_CODE = '0;

  logic atZero;
  assign atMax  = (count == MAX_CODE);
  assign atZero = (count == ZERO_CODE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count  <= ZERO_CODE;
      result <= ZERO_CODE;
    end else begin
      if (strb.clear)                count <= ZERO_CODE;
      else if (strb.inc && !atMax)   count <= count + 1'b1;
      else if (strb.dec && !atZero)  count <= count - 1'b1;
      if (strb.capture)              result <= count;
    end
  end

  // R6: the counter never wraps from all ones to zero except by clear
  p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(count) == MAX_CODE && !$past(strb.clear)) |-> count != ZERO_CODE);

  // R8: the counter never wraps from zero to all ones
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(count) == ZERO_CODE && !$past(strb.inc)) |-> count == ZERO_CODE);

  // R3 / R7: outside a clear, the code moves by at most one step per clock
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.clear) |->
      (count == $past(count)) || (count == $past(count) + 1'b1) ||
      (count == $past(count) - 1'b1));
endmodule

// File: rtl/rta_control.sv
module rta_control
  import rta_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       trackMode,
  input  logic       cmpAbove,
  input  logic       atMax,
  output rtaStrobe_t strb,
  output logic       resultValid,
  output logic       fullScale
);
  rtaState_t state;
  logic      prevUp;    // direction of the previous tracking step
  logic      havePrev;  // a previous tracking step exists
  logic      wantUp;

  assign wantUp = !cmpAbove;

  always_comb begin
    strb = '0;
    if (trackMode) begin
      if (state == ST_TRACK) begin
        strb.inc     = wantUp;
        strb.dec     = !wantUp;
        strb.capture = havePrev && (prevUp != wantUp);
      end
    end else if (startReq) begin
      strb.clear = 1'b1;
    end else if (state == ST_RAMP) begin
      if (cmpAbove || atMax) strb.capture = 1'b1;
      else                   strb.inc     = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      resultValid <= 1'b0;
      fullScale   <= 1'b0;
      prevUp      <= 1'b0;
      havePrev    <= 1'b0;
    end else if (trackMode) begin
      fullScale <= 1'b0;
      if (state != ST_TRACK) begin
        state       <= ST_TRACK;
        resultValid <= 1'b0;
        havePrev    <= 1'b0;
      end else begin
        resultValid <= strb.capture;
        prevUp      <= wantUp;
        havePrev    <= 1'b1;
      end
    end else if (startReq) begin
      state       <= ST_RAMP;
      resultValid <= 1'b0;
      fullScale   <= 1'b0;
    end else begin
      unique case (state)
        ST_TRACK: begin
          state       <= ST_IDLE;
          resultValid <= 1'b0;
        end
        ST_RAMP: begin
          if (cmpAbove) begin
            state       <= ST_DONE;
            resultValid <= 1'b1;
          end else if (atMax) begin
            state       <= ST_DONE;
            resultValid <= 1'b1;
            fullScale   <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R2: a ramp start always leaves the result invalid
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !trackMode) |=> !resultValid && !fullScale);
endmodule

// File: rtl/ramp_track_adc.sv
module ramp_track_adc
  import rta_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         trackMode,
  input  logic         cmpAbove,
  output logic [W-1:0] dacCode,
  output logic [W-1:0] resultCode,
  output logic         resultValid,
  output logic         fullScale
);
  localparam logic [W-1:0] MAX_CODE = {W{1'b1}};

  rtaStrobe_t strb;
  logic       atMax;

  rta_control u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .trackMode(trackMode),
    .cmpAbove(cmpAbove), .atMax(atMax), .strb(strb),
    .resultValid(resultValid), .fullScale(fullScale)
  );

  rta_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .count(dacCode), .result(resultCode), .atMax(atMax)
  );

  // R5: a finished ramp keeps its code frozen
  p_ramp_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !trackMode && !startReq) |=> $stable(dacCode));

  // R4: a ramp result appears only after a comparator trip or at full scale
  p_trip_before_valid_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(resultValid) && !$past(trackMode)) |-> ($past(cmpAbove) || fullScale));

  // R6: full scale flag implies an all-ones valid result
  p_full_scale_code_r6: assert property (@(posedge clk) disable iff (!rstN)
    fullScale |-> (resultValid && resultCode == MAX_CODE));
endmodule

// File: tb/test_ramp_track_adc.sv
`timescale 1ns/1ps
module test_ramp_track_adc;
  localparam int W   = 6;
  localparam int MAX = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic         trackMode = 1'b0;
  logic         cmpAbove;
  logic [W-1:0] dacCode;
  logic [W-1:0] resultCode;
  logic         resultValid;
  logic         fullScale;

  int vin = 0;            // held analog input, in LSB units
  int nChecks = 0;
  int nFails  = 0;

  always #2.5 clk = ~clk; // 200 MHz

  // analog model: ideal DAC plus comparator
  assign cmpAbove = (int'(dacCode) > vin);

  ramp_track_adc #(.W(W)) i_ramp_track_adc (
    .clk(clk), .rstN(rstN), .startReq(startReq), .trackMode(trackMode),
    .cmpAbove(cmpAbove), .dacCode(dacCode), .resultCode(resultCode),
    .resultValid(resultValid), .fullScale(fullScale)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  function automatic int absDiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  task automatic testReset;
    rstN = 1'b0;
    tick(3);
    rstN = 1'b1;
    check(dacCode == 0, "R1 dacCode", dacCode, 0);
    check(resultValid == 0, "R1 resultValid", resultValid, 0);
    check(fullScale == 0, "R1 fullScale", fullScale, 0);
  endtask

  // ramp conversion for input level v; expects code v+1 capped at MAX
  task automatic testRamp(input int v);
    int expCode;
    int lat;
    expCode = (v >= MAX) ? MAX : v + 1;
    vin = v;
    startReq = 1'b1;
    tick(1);
    startReq = 1'b0;
    check(dacCode == 0, "R2 cleared code", dacCode, 0);
    check(resultValid == 0, "R2 valid low", resultValid, 0);
    lat = 0;
    while (!resultValid && lat < MAX + 8) begin
      tick(1);
      lat++;
      if (!resultValid) check(int'(dacCode) == lat, "R3 ramp step", dacCode, lat);
    end
    check(lat == expCode + 1, "R4 latency", lat, expCode + 1);
    check(int'(resultCode) == expCode, "R4 result", resultCode, expCode);
    check(fullScale == (v >= MAX), "R6 fullScale", fullScale, int'(v >= MAX));
    tick(3);
    check(resultValid == 1, "R5 valid held", resultValid, 1);
    check(int'(dacCode) == expCode, "R5 code held", dacCode, expCode);
    check(int'(resultCode) == expCode, "R5 result held", resultCode, expCode);
  endtask

  task automatic testRestartMidRamp;
    vin = 50;
    startReq = 1'b1;
    tick(1);
    startReq = 1'b0;
    tick(10);
    check(resultValid == 0, "R2 running", resultValid, 0);
    testRamp(3);
  endtask

  task automatic testTrackFollow;
    vin = 20;
    trackMode = 1'b1;
    tick(80);
    for (int lvl = 20; lvl <= 50; lvl++) begin
      vin = lvl;
      for (int k = 0; k < 4; k++) begin
        tick(1);
        check(absDiff(int'(dacCode), vin) <= 1, "R7 follow up", dacCode, vin);
      end
    end
    for (int lvl = 50; lvl >= 10; lvl--) begin
      vin = lvl;
      for (int k = 0; k < 4; k++) begin
        tick(1);
        check(absDiff(int'(dacCode), vin) <= 1, "R7 follow down", dacCode, vin);
      end
    end
  endtask

  task automatic testTrackReversal;
    vin = 30;
    tick(80);
    check(resultValid == 1, "R9 valid on reversal", resultValid, 1);
    check(absDiff(int'(resultCode), int'(dacCode)) == 1, "R9 captured pre-step",
          resultCode, dacCode);
    check(dacCode == 30 || dacCode == 31, "R7 bracket", dacCode, 30);
    vin = 60;
    tick(2);
    for (int k = 0; k < 15; k++) begin
      tick(1);
      check(resultValid == 0, "R9 no valid while climbing", resultValid, 0);
    end
  endtask

  task automatic testTrackSaturate;
    vin = MAX + 5;
    tick(80);
    check(int'(dacCode) == MAX, "R8 top rail", dacCode, MAX);
    tick(3);
    check(int'(dacCode) == MAX, "R8 top held", dacCode, MAX);
    check(resultValid == 0, "R9 no reversal at top", resultValid, 0);
    vin = -5;
    tick(80);
    check(dacCode == 0, "R8 bottom rail", dacCode, 0);
    tick(3);
    check(dacCode == 0, "R8 bottom held", dacCode, 0);
    check(resultValid == 0, "R9 no reversal at bottom", resultValid, 0);
  endtask

  task automatic testTrackIgnoresStart;
    vin = 40;
    tick(80);
    startReq = 1'b1;
    tick(1);
    startReq = 1'b0;
    check(absDiff(int'(dacCode), 40) <= 1, "R10 start ignored", dacCode, 40);
    tick(2);
    check(absDiff(int'(dacCode), 40) <= 1, "R10 code kept", dacCode, 40);
    check(resultValid == 1, "R10 tracking continues", resultValid, 1);
  endtask

  task automatic testTrackExit;
    int held;
    held = int'(dacCode);
    trackMode = 1'b0;
    tick(1);
    check(resultValid == 0, "R11 valid dropped", resultValid, 0);
    check(int'(dacCode) == held, "R11 code kept", dacCode, held);
    tick(2);
    check(int'(dacCode) == held, "R11 code idle", dacCode, held);
  endtask

  initial begin
    #(200000 * 5);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    for (int v = -1; v <= MAX + 2; v++) testRamp(v);
    testRestartMidRamp();
    testTrackFollow();
    testTrackReversal();
    testTrackSaturate();
    testTrackIgnoresStart();
    testTrackExit();
    testRamp(17);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule